// File: doc/BRIEF.md
# Collision-Free Initiation Controller for a Feedback Pipeline

This block decides, cycle by cycle, whether a new task may enter a multi-stage pipeline whose stages are reused at several points of one evaluation. The stage usage of one evaluation is fixed, so some spacings between two task starts make two tasks claim the same stage in the same cycle. A forbidden-latency mask (bit j set means a spacing of j+1 cycles is forbidden) captures these spacings. The controller keeps a shift-register state built from this mask. It grants a start only when no task already in flight would collide with the new one.

Requests are held until granted. Two scheduling policies are available. The greedy policy starts a waiting task at the first legal cycle. The fixed policy also waits until at least a programmed spacing has passed since the previous start. The controller also replays the per-task stage usage pattern for the tasks it has granted. It reports which stages are busy in each cycle, with running totals of busy stage-slots and elapsed cycles, so that pipeline utilisation can be computed.

Top module: `initiation_ctrl`

## Requirements
- R1: During and directly after reset, `state_o` equals the forbidden-latency mask, and `busy_slots_o`, `cycles_o` and `busy_now_o` are 0.
- R2: In a cycle without a grant, the next `state_o` is the current one shifted right by one, with 0 entering the top bit.
- R3: `grant_o` is high only in a cycle where `state_o[0]` is 0, and `allow_o` is low whenever `state_o[0]` is 1.
- R4: In a cycle with a grant, the next `state_o` is the current one shifted right by one, OR-ed with the mask.
- R5: After more than M cycles without a grant, `state_o` is all zero, and a grant from that state leaves `state_o` equal to the mask.
- R6: With `mode_i`=0 (greedy), a waiting task is granted in the first cycle where `state_o[0]` is 0.
- R7: With `mode_i`=1 (fixed), a grant also needs at least `lat_i` cycles since the previous grant. Before the first grant after reset, this spacing condition counts as met.
- R8: A request seen in a cycle without a grant stays pending, without `req_i` held high, until it is granted. One request gives exactly one grant.
- R9: No stage is used by two granted tasks in the same cycle. Stage s is used c cycles after a start when bit s*(M+1)+c of the usage-pattern parameter is 1.
- R10: `busy_now_o` counts the stages busy in the current cycle, including those used by a grant made in that cycle. `busy_slots_o` is the sum of `busy_now_o` over all earlier cycles since reset, and `cycles_o` counts those cycles. With mask 1011010 on the default 3-stage pattern and a fixed spacing of 3, any 9 steady-state cycles add 24 busy slots, which is 8 of every 9.
- R11: With the mask source parameter at 0, the mask comes from a parameter and `cv_i` has no effect on `state_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cv_i | input | M | Forbidden-latency mask, used when the mask source parameter is 1 |
| mode_i | input | 1 | 0 = greedy, 1 = fixed spacing |
| lat_i | input | LAT_W | Minimum spacing in fixed mode |
| req_i | input | 1 | Request to start a task |
| allow_o | output | 1 | A start is legal in this cycle |
| grant_o | output | 1 | A task starts in this cycle |
| state_o | output | M | Collision state; bit j forbids a start j cycles from now |
| stage_busy_o | output | NS | Per-stage busy flags for the current cycle |
| busy_now_o | output | $clog2(NS+1) | Number of busy stages in the current cycle |
| busy_slots_o | output | CNT_W | Accumulated busy stage-slots |
| cycles_o | output | CNT_W | Cycles elapsed since reset |

## Verification
Properties are checked on every cycle for the following: the state update with and without a grant, grants only on a clear low state bit, greedy service of a held request, and the absence of two tasks on any one stage. Some behaviour only the bench scenarios can show. These are the decay to an all-zero state and the reload of the mask, and the fixed-spacing policy across a sweep of spacings, including forbidden ones. They also include the exact busy-slot totals and the 8-of-9 steady-state utilisation. The bench checks these against a model that tests each candidate start against every earlier start.

// File: rtl/pic_pkg.sv
package pic_pkg;
   typedef enum logic {
      SCHED_GREEDY = 1'b0,
      SCHED_FIXED  = 1'b1
   } sched_e;

   function automatic int unsigned ones_count(input logic [63:0] v, input int unsigned n);
      int unsigned acc;
      acc = 0;
      for (int unsigned i = 0; i < n; i++) acc += int'(v[i]);
      return acc;
   endfunction
endpackage

// File: rtl/pic_state.sv
module pic_state #(
   parameter int unsigned     M      = 7,
   parameter bit              CV_SEL = 1'b0,
   parameter logic [M-1:0]    CV_PAR = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [M-1:0] cv_i,
   input  logic         grant_i,
   output logic [M-1:0] mask_o,
   output logic [M-1:0] state_o
);
   logic [M-1:0] mask;
   logic [M-1:0] st_q;
   logic [M-1:0] shifted;

   generate
      if (CV_SEL) begin : g_mask_port
         assign mask = cv_i;
      end else begin : g_mask_param
         logic unused_cv;
         assign unused_cv = ^cv_i;
         assign mask = CV_PAR;
      end
   endgenerate

   assign shifted = st_q >> 1;

   always_ff @(posedge clk) begin
      if (!rst_n)       st_q <= mask;
      else if (grant_i) st_q <= shifted | mask;
      else              st_q <= shifted;
   end

   assign mask_o  = mask;
   assign state_o = st_q;
endmodule

// File: rtl/pic_policy.sv
module pic_policy import pic_pkg::*; #(
   parameter int unsigned LAT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_i,
   input  logic [LAT_W-1:0] lat_i,
   input  logic             req_i,
   input  logic             blocked_i,
   output logic             allow_o,
   output logic             grant_o
);
   localparam logic [LAT_W-1:0] GAP_SAT = '1;

   sched_e           mode;
   logic [LAT_W-1:0] gap_q;
   logic             pend_q;
   logic             want;
   logic             spacing_ok;

   assign mode = sched_e'(mode_i);

   always_comb begin
      unique case (mode)
         SCHED_GREEDY: spacing_ok = 1'b1;
         SCHED_FIXED:  spacing_ok = (gap_q >= lat_i);
         default:      spacing_ok = 1'b0;
      endcase
   end

   assign want    = pend_q | req_i;
   assign allow_o = ~blocked_i & spacing_ok;
   assign grant_o = want & allow_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q  <= GAP_SAT;
         pend_q <= 1'b0;
      end else begin
         if (grant_o)              gap_q <= LAT_W'(1);
         else if (gap_q != GAP_SAT) gap_q <= gap_q + LAT_W'(1);
         pend_q <= want & ~grant_o;
      end
   end
endmodule

// File: rtl/pic_occupancy.sv
module pic_occupancy import pic_pkg::*; #(
   parameter int unsigned       NS    = 3,
   parameter int unsigned       T     = 8,
   parameter logic [NS*T-1:0]   RT    = '0,
   parameter int unsigned       CNT_W = 16,
   localparam int unsigned      BC_W  = $clog2(NS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             grant_i,
   output logic [T-1:0]     live_o,
   output logic [NS-1:0]    stage_busy_o,
   output logic [BC_W-1:0]  busy_now_o,
   output logic [CNT_W-1:0] busy_slots_o,
   output logic [CNT_W-1:0] cycles_o
);
   logic [T-2:0]     hist_q;
   logic [T-1:0]     live;
   logic [CNT_W-1:0] slots_q;
   logic [CNT_W-1:0] cyc_q;

   assign live = {hist_q, grant_i};

   genvar s;
   generate
      for (s = 0; s < NS; s++) begin : g_stage
         assign stage_busy_o[s] = |(live & RT[s*T +: T]);
      end
   endgenerate

   assign busy_now_o = BC_W'(ones_count(64'(stage_busy_o), NS));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_q  <= '0;
         slots_q <= '0;
         cyc_q   <= '0;
      end else begin
         hist_q  <= live[T-2:0];
         slots_q <= slots_q + CNT_W'(busy_now_o);
         cyc_q   <= cyc_q + CNT_W'(1);
      end
   end

   assign live_o       = live;
   assign busy_slots_o = slots_q;
   assign cycles_o     = cyc_q;
endmodule

// File: rtl/initiation_ctrl.sv
module initiation_ctrl import pic_pkg::*; #(
   parameter int unsigned               M      = 7,
   parameter logic [M-1:0]              CV     = 7'b1011010,
   parameter bit                        CV_SEL = 1'b0,
   parameter int unsigned               NS     = 3,
   parameter logic [NS*(M+1)-1:0]       RT     = 24'b01010100_00001010_10100001,
   parameter int unsigned               LAT_W  = 4,
   parameter int unsigned               CNT_W  = 16,
   localparam int unsigned              T      = M + 1,
   localparam int unsigned              BC_W   = $clog2(NS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [M-1:0]     cv_i,
   input  logic             mode_i,
   input  logic [LAT_W-1:0] lat_i,
   input  logic             req_i,
   output logic             allow_o,
   output logic             grant_o,
   output logic [M-1:0]     state_o,
   output logic [NS-1:0]    stage_busy_o,
   output logic [BC_W-1:0]  busy_now_o,
   output logic [CNT_W-1:0] busy_slots_o,
   output logic [CNT_W-1:0] cycles_o
);
   generate
      if (M < 1 || M > 63) begin : g_bad_m
         $error("initiation_ctrl: M must lie in 1..63");
      end
      if (NS < 1 || NS > 64) begin : g_bad_ns
         $error("initiation_ctrl: NS must lie in 1..64");
      end
      if ((64'd1 << LAT_W) <= 64'(M + 1)) begin : g_bad_lat
         $error("initiation_ctrl: LAT_W too narrow to express spacing M+1");
      end
      if (CNT_W < 4) begin : g_bad_cnt
         $error("initiation_ctrl: CNT_W must be at least 4");
      end
   endgenerate

   logic [M-1:0] cv_eff;
   logic [T-1:0] live_tasks;
   logic         grant;

   pic_state #(
      .M      (M),
      .CV_SEL (CV_SEL),
      .CV_PAR (CV)
   ) u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .cv_i    (cv_i),
      .grant_i (grant),
      .mask_o  (cv_eff),
      .state_o (state_o)
   );

   pic_policy #(
      .LAT_W (LAT_W)
   ) u_policy (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_i    (mode_i),
      .lat_i     (lat_i),
      .req_i     (req_i),
      .blocked_i (state_o[0]),
      .allow_o   (allow_o),
      .grant_o   (grant)
   );

   pic_occupancy #(
      .NS    (NS),
      .T     (T),
      .RT    (RT),
      .CNT_W (CNT_W)
   ) u_occ (
      .clk          (clk),
      .rst_n        (rst_n),
      .grant_i      (grant),
      .live_o       (live_tasks),
      .stage_busy_o (stage_busy_o),
      .busy_now_o   (busy_now_o),
      .busy_slots_o (busy_slots_o),
      .cycles_o     (cycles_o)
   );

   assign grant_o = grant;
endmodule

// File: rtl/pic_checker.sv
module pic_checker import pic_pkg::*; #(
   parameter int unsigned         M  = 7,
   parameter int unsigned         NS = 3,
   parameter int unsigned         T  = 8,
   parameter logic [NS*T-1:0]     RT = '0
) (
   input logic         clk,
   input logic         rst_n,
   input logic         mode_i,
   input logic         req_i,
   input logic         grant_o,
   input logic         allow_o,
   input logic [M-1:0] state_o,
   input logic [M-1:0] cv,
   input logic [T-1:0] live
);
   // R3
   assert_grant_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o |-> !state_o[0]);
   assert_allow_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      state_o[0] |-> !allow_o);

   // R2
   assert_idle_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !grant_o |=> state_o == ($past(state_o) >> 1));

   // R4
   assert_grant_merge_R4: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o |=> state_o == (($past(state_o) >> 1) | $past(cv)));

   // R6 and R8
   assert_greedy_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(req_i) && !$past(grant_o) && !state_o[0]
       && (mode_i == SCHED_GREEDY)) |-> grant_o);

   // R9
   genvar s;
   generate
      for (s = 0; s < NS; s++) begin : g_excl
         assert_stage_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(live & RT[s*T +: T]) <= 1);
      end
   endgenerate
endmodule

bind initiation_ctrl pic_checker #(
   .M  (M),
   .NS (NS),
   .T  (T),
   .RT (RT)
) u_pic_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .mode_i  (mode_i),
   .req_i   (req_i),
   .grant_o (grant_o),
   .allow_o (allow_o),
   .state_o (state_o),
   .cv      (cv_eff),
   .live    (live_tasks)
);

// File: tb/tb_initiation_ctrl.sv
module tb_initiation_ctrl;
   localparam int CLK_P = 10;
   localparam int M  = 7;
   localparam int NS = 3;
   localparam int T  = M + 1;
   localparam logic [NS*T-1:0] RT = 24'b01010100_00001010_10100001;
   localparam logic [M-1:0] CV_CFG = 7'b1011010;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [M-1:0] cv_i = 7'b0100101;
   logic mode_i = 1'b0;
   logic [3:0] lat_i = 4'd0;
   logic req_i = 1'b0;
   logic allow_o, grant_o;
   logic [M-1:0] state_o;
   logic [NS-1:0] stage_busy_o;
   logic [1:0] busy_now_o;
   logic [15:0] busy_slots_o, cycles_o;

   always #(CLK_P/2) clk = ~clk;

   initiation_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cv_i(cv_i), .mode_i(mode_i), .lat_i(lat_i),
      .req_i(req_i), .allow_o(allow_o), .grant_o(grant_o), .state_o(state_o),
      .stage_busy_o(stage_busy_o), .busy_now_o(busy_now_o),
      .busy_slots_o(busy_slots_o), .cycles_o(cycles_o));

   int total = 0;
   int bad = 0;
   logic [M-1:0] fmask;
   int starts[0:2047];
   int n_st;
   int t_now;
   bit pend_m;
   int last_g;
   int slot_sum;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0d)", req, act, exp, t_now);
      end
   endtask

   function automatic logic [M-1:0] mask_from_table();
      logic [M-1:0] m = '0;
      for (int s = 0; s < NS; s++)
         for (int a = 0; a < T; a++)
            for (int b = a + 1; b < T; b++)
               if (RT[s*T+a] && RT[s*T+b]) m[b-a-1] = 1'b1;
      return m;
   endfunction

   function automatic logic [M-1:0] model_state(input int t);
      logic [M-1:0] st = '0;
      for (int i = 0; i < n_st; i++) begin
         int d = t - starts[i];
         for (int j = 0; j < M; j++) begin
            int k = d + j;
            if (k >= 1 && k <= M && fmask[k-1]) st[j] = 1'b1;
         end
      end
      return st;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0; req_i = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_now = 0; n_st = 1; starts[0] = -1; pend_m = 0;
      last_g = -1000; slot_sum = 0;
   endtask

   task automatic cycle(input bit r, input bit md, input int lat);
      logic [M-1:0] est;
      bit allow_m, grant_m;
      int busy_m, gap;
      req_i = r; mode_i = md; lat_i = 4'(lat);
      @(negedge clk);
      est = model_state(t_now);
      gap = t_now - last_g;
      if (gap > 15) gap = 15;
      allow_m = !est[0] && (md == 1'b0 || gap >= lat);
      grant_m = (pend_m || r) && allow_m;
      chk(state_o == est, "R2/R4 state", int'(state_o), int'(est));
      chk(allow_o == allow_m, md ? "R7 allow" : "R3 allow", int'(allow_o), int'(allow_m));
      chk(grant_o == grant_m, md ? "R7 grant" : "R6/R8 grant", int'(grant_o), int'(grant_m));
      if (grant_m) begin
         starts[n_st] = t_now; n_st++; last_g = t_now;
      end
      pend_m = (pend_m || r) && !grant_m;
      busy_m = 0;
      for (int s = 0; s < NS; s++) begin
         int users = 0;
         for (int i = 1; i < n_st; i++) begin
            int c = t_now - starts[i];
            if (c >= 0 && c < T && RT[s*T+c]) users++;
         end
         if (users > 1) chk(1'b0, "R9 stage overlap", users, 1);
         if (users > 0) busy_m++;
      end
      chk(int'(busy_now_o) == busy_m, "R10 busy_now", int'(busy_now_o), busy_m);
      chk(int'(busy_slots_o) == slot_sum, "R10 busy_slots", int'(busy_slots_o), slot_sum);
      chk(int'(cycles_o) == t_now, "R10 cycles", int'(cycles_o), t_now);
      slot_sum += busy_m;
      @(posedge clk); #1;
      t_now++;
   endtask

   initial begin
      #(CLK_P * 150000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int s30;
      logic [15:0] lfsr;
      fmask = mask_from_table();
      chk(fmask == CV_CFG, "R9 table mask", int'(fmask), int'(CV_CFG));

      // R1 and R11: reset state while a different mask is driven on cv_i
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(state_o == CV_CFG, "R1/R11 state in reset", int'(state_o), int'(CV_CFG));
      chk(busy_slots_o == 0 && cycles_o == 0 && busy_now_o == 0, "R1 counters", int'(busy_slots_o), 0);
      do_reset();
      @(negedge clk);
      chk(state_o == CV_CFG, "R1/R11 state after reset", int'(state_o), int'(CV_CFG));
      @(posedge clk); #1;
      cv_i = 7'b1111111;

      // Greedy, continuous requests (R6, R9, R10)
      do_reset();
      for (int i = 0; i < 60; i++) cycle(1'b1, 1'b0, 0);

      // Fixed spacing sweep including forbidden spacings (R7)
      for (int L = 0; L <= 9; L++) begin
         do_reset();
         for (int i = 0; i < 40; i++) cycle(1'b1, 1'b1, L);
      end

      // Fixed spacing 3: steady state utilisation 8 of 9 (R10)
      do_reset();
      s30 = 0;
      for (int i = 0; i < 45; i++) begin
         if (t_now == 30) s30 = int'(busy_slots_o);
         if (t_now == 39) chk(int'(busy_slots_o) - s30 == 24, "R10 steady 24 of 27",
                              int'(busy_slots_o) - s30, 24);
         cycle(1'b1, 1'b1, 3);
      end

      // Single-cycle request pulses, both modes (R8)
      for (int md = 0; md < 2; md++) begin
         do_reset();
         lfsr = 16'hACE1;
         for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cycle(lfsr[0] & lfsr[3], md[0], 2 + (i % 5));
         end
      end

      // Idle decay and reload (R5)
      do_reset();
      cycle(1'b1, 1'b0, 0);
      for (int i = 0; i < M + 2; i++) cycle(1'b0, 1'b0, 0);
      @(negedge clk);
      chk(state_o == '0, "R5 decayed state", int'(state_o), 0);
      @(posedge clk); #1;
      t_now++;
      cycle(1'b1, 1'b0, 0);
      @(negedge clk);
      chk(state_o == CV_CFG, "R5 reload mask", int'(state_o), int'(CV_CFG));

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule